// File: doc/BRIEF.md
# Spiking Neuron Core Update Engine

This block advances a bank of integrate-and-fire neurons by one discrete time step each time it receives a tick-start pulse. The step takes a binary vector of axon inputs and passes it through a binary connection matrix. The neurons are processed one after another through a single shared datapath. For each neuron, the engine walks the axons in ascending order. It adds the neuron's own signed weight for the type of every active, connected axon, then adds the neuron's leak. It then compares the membrane potential against the neuron's threshold. When the potential reaches the threshold, the engine emits a spike event that carries the neuron index and loads the neuron's reset value.

Every axon carries a 2-bit type, and every neuron holds one signed 9-bit weight per type. The connection matrix stores only connect bits. Neurons can be switched into a stochastic mode, in which a 16-bit LFSR on the core decides whether each connection integrates. The same LFSR can also add a random offset to the threshold. All configuration is held in internal register arrays. It is loaded through a single-cycle write port that is selected by a 3-bit kind code.

Top module: `neuro_core_engine`

## Requirements
- R1: While reset is asserted, all membrane potentials and all configuration are cleared and the outputs are low. With the cleared configuration (weights 0, leak 0, threshold 0, reset value 0), every neuron fires on a tick.
- R2: In deterministic mode, neuron n adds the weight it holds for the type of axon a whenever axon a is active in the vector latched at tick start and the connect bit (n,a) is 1. A type code t in 0..3 selects weight slot t.
- R3: The 20-bit signed potential saturates at +524287 and at -524288 after every addition and never wraps.
- R4: For each neuron, the engine first integrates all axons, then adds the leak once, then tests whether potential >= effective threshold. On a fire, it pulses spike_valid with spike_idx equal to n and loads the reset value. Without a fire, the potential is kept.
- R5: The signed 9-bit leak is added once per tick even when no axon is active.
- R6: In stochastic-integration mode, every active connected axon draws the LFSR. The connection adds +1 (for a positive weight) or -1 (for a negative weight) only when the low 8 LFSR bits, as an unsigned value, are below |weight|. Otherwise it adds 0.
- R7: In stochastic-threshold mode, the effective threshold is the threshold plus (low 8 LFSR bits AND the neuron's 8-bit mask), drawn once per neuron after the leak. In the other mode, it is the plain threshold.
- R8: The LFSR shifts right once per draw, XORing 0xB400 when the bit shifted out is 1. A draw uses the value before the shift. Draws follow neuron order, then axon order, with the threshold draw last for each neuron. Writing seed 0 loads 0x0001.
- R9: Neurons are processed in ascending index order, so spike indices within a tick rise strictly and each neuron spikes at most once.
- R10: tick_done pulses once per tick, on the (N_NEUR*(N_AXON+2)+1)-th rising edge, counting the edge that accepts tick_start as the first.
- R11: A tick_start seen while the engine is busy pulses tick_err on the next cycle and changes neither the running tick nor its timing.
- R12: The write port codes are as follows. 0 writes the connect bit (row = neuron, col = axon, data[0]). 1 writes the axon type (col, data[1:0]). 2 writes a weight (row, col[1:0] = type slot, data[8:0]). 3 writes the leak (row, data[8:0]). 4 writes the threshold (row, data[19:0]). 5 writes the reset value (row, data[19:0]). 6 writes the stochastic configuration (row; data[0] = stochastic integration, data[1] = stochastic threshold, data[9:2] = mask). 7 writes the seed (data[15:0]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_start | input | 1 | Single-cycle pulse that starts a time step |
| axon_in | input | N_AXON | Axon activity vector, latched at tick start |
| wr_en | input | 1 | Configuration write strobe |
| wr_kind | input | 3 | Selects which array is written |
| wr_row | input | log2(N_NEUR) | Neuron index for the write |
| wr_col | input | log2(N_AXON) | Axon index or weight slot for the write |
| wr_data | input | 20 | Write data |
| spike_valid | output | 1 | Spike event strobe |
| spike_idx | output | log2(N_NEUR) | Index of the firing neuron |
| tick_done | output | 1 | Pulse after the last neuron of the step |
| tick_err | output | 1 | Pulse when tick_start arrives while busy |

## Verification
The checks assume that tick_start is a one-cycle pulse. They also assume that configuration writes happen only while the engine is idle, because a write during a walk would mix old and new parameters within one neuron. The bench drives every write between ticks and raises tick_start while busy only on purpose, to exercise the error flag. Neuron and axon counts are taken as powers of two with at least four axons, so the index counters wrap exactly and a column index can address all four weight slots. The bench runs a 8-axon, 4-neuron configuration that meets these conditions.

// File: rtl/nce_pkg.sv
package nce_pkg;

  typedef logic signed [19:0] pot_t;

  typedef enum logic [1:0] {ST_IDLE, ST_INTEG, ST_LEAK, ST_FIRE} st_e;

  typedef enum logic [2:0] {
    WK_CONN   = 3'd0,
    WK_TYPE   = 3'd1,
    WK_WEIGHT = 3'd2,
    WK_LEAK   = 3'd3,
    WK_THR    = 3'd4,
    WK_RSTV   = 3'd5,
    WK_STOCH  = 3'd6,
    WK_SEED   = 3'd7
  } wkind_e;

  // Add with clamp to the 20-bit signed range.
  function automatic pot_t sat_add(pot_t a, logic signed [20:0] b);
    logic signed [21:0] s;
    s = 22'(a) + 22'(b);
    if (s > 22'sd524287)       return 20'sh7FFFF;
    else if (s < -22'sd524288) return 20'sh80000;
    else                       return pot_t'(s[19:0]);
  endfunction

endpackage

// File: rtl/nce_lfsr.sv
module nce_lfsr (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [15:0] seed,
  input  logic        step,
  output logic [7:0]  rnd
);
  logic [15:0] q, d;

  always_comb begin
    d = q;
    if (load)      d = (seed == 16'h0000) ? 16'h0001 : seed;
    else if (step) d = {1'b0, q[15:1]} ^ (q[0] ? 16'hB400 : 16'h0000);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           q <= 16'h0001;
    else if (load | step) q <= d;
  end

  assign rnd = q[7:0];
endmodule

// File: rtl/nce_syn_eval.sv
module nce_syn_eval (
  input  logic              hit,
  input  logic              stoch,
  input  logic signed [8:0] weight,
  input  logic [7:0]        rnd,
  output logic signed [9:0] addend,
  output logic              draw
);
  logic signed [9:0] w10;
  logic [9:0]        mag;
  logic              pass;

  always_comb begin
    w10  = 10'(weight);
    mag  = w10[9] ? 10'(-w10) : 10'(w10);
    pass = {2'b00, rnd} < mag;
    draw = hit & stoch;
    if (!hit)       addend = 10'sd0;
    else if (!stoch) addend = w10;
    else if (!pass)  addend = 10'sd0;
    else            addend = w10[9] ? -10'sd1 : 10'sd1;
  end
endmodule

// File: rtl/nce_seq.sv
module nce_seq import nce_pkg::*; #(
  parameter int N_AXON = 256,
  parameter int N_NEUR = 256,
  localparam int AW   = $clog2(N_AXON),
  localparam int NWID = $clog2(N_NEUR)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_start,
  output st_e             st,
  output logic [NWID-1:0] nidx,
  output logic [AW-1:0]   aidx,
  output logic            start,
  output logic            busy,
  output logic            done,
  output logic            err
);
  localparam logic [AW-1:0]   A_LAST = AW'(N_AXON - 1);
  localparam logic [NWID-1:0] N_LAST = NWID'(N_NEUR - 1);

  st_e             st_q, st_d;
  logic [NWID-1:0] n_q, n_d;
  logic [AW-1:0]   a_q, a_d;
  logic            done_d, err_d, done_q, err_q;

  always_comb begin
    st_d   = st_q;
    n_d    = n_q;
    a_d    = a_q;
    done_d = 1'b0;
    err_d  = tick_start && (st_q != ST_IDLE);
    case (st_q)
      ST_IDLE: if (tick_start) begin
        st_d = ST_INTEG;
        n_d  = '0;
        a_d  = '0;
      end
      ST_INTEG: begin
        if (a_q == A_LAST) begin
          a_d  = '0;
          st_d = ST_LEAK;
        end else begin
          a_d = a_q + 1'b1;
        end
      end
      ST_LEAK: st_d = ST_FIRE;
      default: begin
        if (n_q == N_LAST) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          n_d  = n_q + 1'b1;
          st_d = ST_INTEG;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      n_q    <= '0;
      a_q    <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      n_q    <= n_d;
      a_q    <= a_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign st    = st_q;
  assign nidx  = n_q;
  assign aidx  = a_q;
  assign start = (st_q == ST_IDLE) && tick_start;
  assign busy  = (st_q != ST_IDLE);
  assign done  = done_q;
  assign err   = err_q;
endmodule

// File: rtl/neuro_core_engine.sv
module neuro_core_engine import nce_pkg::*; #(
  parameter int N_AXON = 256,
  parameter int N_NEUR = 256,
  localparam int AW   = $clog2(N_AXON),
  localparam int NWID = $clog2(N_NEUR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_start,
  input  logic [N_AXON-1:0] axon_in,
  input  logic              wr_en,
  input  logic [2:0]        wr_kind,
  input  logic [NWID-1:0]   wr_row,
  input  logic [AW-1:0]     wr_col,
  input  logic [19:0]       wr_data,
  output logic              spike_valid,
  output logic [NWID-1:0]   spike_idx,
  output logic              tick_done,
  output logic              tick_err
);
  // configuration and state arrays
  logic [N_AXON-1:0] conn_q [N_NEUR];
  logic [1:0]        type_q [N_AXON];
  logic signed [8:0] wt_q   [N_NEUR][4];
  logic signed [8:0] leak_q [N_NEUR];
  pot_t              thr_q  [N_NEUR];
  pot_t              rstv_q [N_NEUR];
  pot_t              pot_q  [N_NEUR];
  logic              sti_q  [N_NEUR];
  logic              stt_q  [N_NEUR];
  logic [7:0]        mask_q [N_NEUR];

  logic [N_AXON-1:0] ax_q;
  pot_t              acc_q, acc_d, acc_base, pot_next;
  logic              acc_en;
  st_e               st;
  logic [NWID-1:0]   nidx;
  logic [AW-1:0]     aidx;
  logic              start, busy;
  logic              hit, draw_i, step, fire;
  logic signed [8:0] w_sel;
  logic signed [9:0] addend;
  logic [7:0]        rnd, rnd_th;
  logic signed [20:0] eff_thr;
  logic              spk_v_q;
  logic [NWID-1:0]   spk_i_q;
  wkind_e            wk;

  nce_seq #(.N_AXON(N_AXON), .N_NEUR(N_NEUR)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick_start(tick_start),
    .st(st), .nidx(nidx), .aidx(aidx), .start(start), .busy(busy),
    .done(tick_done), .err(tick_err)
  );

  assign wk = wkind_e'(wr_kind);

  nce_lfsr u_lfsr (
    .clk(clk), .rst_n(rst_n),
    .load(wr_en && (wk == WK_SEED)), .seed(wr_data[15:0]),
    .step(step), .rnd(rnd)
  );

  // configuration write port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < N_NEUR; n++) begin
        conn_q[n] <= '0;
        leak_q[n] <= '0;
        thr_q[n]  <= '0;
        rstv_q[n] <= '0;
        sti_q[n]  <= 1'b0;
        stt_q[n]  <= 1'b0;
        mask_q[n] <= '0;
        for (int t = 0; t < 4; t++) wt_q[n][t] <= '0;
      end
      for (int a = 0; a < N_AXON; a++) type_q[a] <= '0;
    end else if (wr_en) begin
      case (wk)
        WK_CONN:   conn_q[wr_row][wr_col]      <= wr_data[0];
        WK_TYPE:   type_q[wr_col]              <= wr_data[1:0];
        WK_WEIGHT: wt_q[wr_row][wr_col[1:0]]   <= wr_data[8:0];
        WK_LEAK:   leak_q[wr_row]              <= wr_data[8:0];
        WK_THR:    thr_q[wr_row]               <= wr_data;
        WK_RSTV:   rstv_q[wr_row]              <= wr_data;
        WK_STOCH: begin
          sti_q[wr_row]  <= wr_data[0];
          stt_q[wr_row]  <= wr_data[1];
          mask_q[wr_row] <= wr_data[9:2];
        end
        default: ;
      endcase
    end
  end

  // synaptic contribution of the current axon
  assign w_sel = wt_q[nidx][type_q[aidx]];
  assign hit   = (st == ST_INTEG) && ax_q[aidx] && conn_q[nidx][aidx];

  nce_syn_eval u_syn (
    .hit(hit), .stoch(sti_q[nidx]), .weight(w_sel), .rnd(rnd),
    .addend(addend), .draw(draw_i)
  );

  // accumulate, leak, threshold
  always_comb begin
    acc_base = (aidx == '0) ? pot_q[nidx] : acc_q;
    acc_en   = 1'b0;
    acc_d    = acc_q;
    case (st)
      ST_INTEG: begin acc_en = 1'b1; acc_d = sat_add(acc_base, 21'(addend)); end
      ST_LEAK:  begin acc_en = 1'b1; acc_d = sat_add(acc_q, 21'(leak_q[nidx])); end
      default: ;
    endcase
    rnd_th   = stt_q[nidx] ? (rnd & mask_q[nidx]) : 8'd0;
    eff_thr  = 21'(thr_q[nidx]) + 21'($signed({1'b0, rnd_th}));
    fire     = 21'(acc_q) >= eff_thr;
    pot_next = fire ? rstv_q[nidx] : acc_q;
    step     = draw_i | ((st == ST_FIRE) && stt_q[nidx]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ax_q <= '0;
    else if (start) ax_q <= axon_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < N_NEUR; n++) pot_q[n] <= '0;
    end else if (st == ST_FIRE) begin
      pot_q[nidx] <= pot_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spk_v_q <= 1'b0;
      spk_i_q <= '0;
    end else begin
      spk_v_q <= (st == ST_FIRE) && fire;
      if (st == ST_FIRE) spk_i_q <= nidx;
    end
  end

  assign spike_valid = spk_v_q;
  assign spike_idx   = spk_i_q;
endmodule

// File: rtl/nce_checker.sv
module nce_checker (
  input logic clk,
  input logic rst_n,
  input logic tick_start,
  input logic busy,
  input logic spike_valid,
  input logic tick_done,
  input logic tick_err
);
  // R9: each neuron takes several cycles, so spikes never come back to back
  a_r9_spike_gap: assert property (@(posedge clk) disable iff (!rst_n)
    spike_valid |=> !spike_valid);

  // R10: done is a single-cycle pulse and leaves the engine idle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tick_done |=> !tick_done);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tick_done |-> !busy);

  // R11: error only follows a start request made while busy
  a_r11_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    tick_err |-> ($past(tick_start) && $past(busy)));

  // R11: a walk only begins from an accepted start
  a_r11_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tick_start));

  // R1: no spike output while the engine rests
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> !spike_valid);
endmodule

bind neuro_core_engine nce_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick_start(tick_start), .busy(busy),
  .spike_valid(spike_valid), .tick_done(tick_done), .tick_err(tick_err)
);

// File: tb/neuro_core_engine_tb.sv
module neuro_core_engine_tb;
  localparam int NA = 8;
  localparam int NN = 4;
  localparam int TICK_LEN = NN * (NA + 2) + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tick_start;
  logic [NA-1:0] axon_in;
  logic          wr_en;
  logic [2:0]    wr_kind;
  logic [1:0]    wr_row;
  logic [2:0]    wr_col;
  logic [19:0]   wr_data;
  logic          spike_valid;
  logic [1:0]    spike_idx;
  logic          tick_done;
  logic          tick_err;

  neuro_core_engine #(.N_AXON(NA), .N_NEUR(NN)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_start(tick_start), .axon_in(axon_in),
    .wr_en(wr_en), .wr_kind(wr_kind), .wr_row(wr_row), .wr_col(wr_col),
    .wr_data(wr_data), .spike_valid(spike_valid), .spike_idx(spike_idx),
    .tick_done(tick_done), .tick_err(tick_err)
  );

  always #2 clk = ~clk;

  int nchk = 0;
  int nerr = 0;

  // reference model state
  int m_conn [NN][NA];
  int m_type [NA];
  int m_wt   [NN][4];
  int m_leak [NN];
  int m_thr  [NN];
  int m_rst  [NN];
  int m_pot  [NN];
  int m_sti  [NN];
  int m_stt  [NN];
  int m_mask [NN];
  int m_lf;

  logic [NN-1:0] got;
  int            last_idx;
  int            order_bad;
  int            err_cnt;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    if (v > 524287)  return 524287;
    if (v < -524288) return -524288;
    return v;
  endfunction

  function automatic int draw();
    int r;
    r    = m_lf & 255;
    m_lf = (m_lf >> 1) ^ (((m_lf & 1) != 0) ? 'hB400 : 0);
    return r;
  endfunction

  always @(negedge clk) begin
    if (spike_valid) begin
      if (int'(spike_idx) <= last_idx || got[spike_idx]) order_bad = 1;
      got[spike_idx] = 1'b1;
      last_idx = int'(spike_idx);
    end
    if (tick_err) err_cnt++;
  end

  task automatic wr(input int kind, input int row, input int col, input int data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_kind = 3'(kind);
    wr_row  = 2'(row);
    wr_col  = 3'(col);
    wr_data = 20'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_conn(input int n, input int a, input int b);
    wr(0, n, a, b); m_conn[n][a] = b;
  endtask
  task automatic set_type(input int a, input int t);
    wr(1, 0, a, t); m_type[a] = t;
  endtask
  task automatic set_wt(input int n, input int t, input int w);
    wr(2, n, t, w); m_wt[n][t] = w;
  endtask
  task automatic set_leak(input int n, input int l);
    wr(3, n, 0, l); m_leak[n] = l;
  endtask
  task automatic set_thr(input int n, input int t);
    wr(4, n, 0, t); m_thr[n] = t;
  endtask
  task automatic set_rst(input int n, input int r);
    wr(5, n, 0, r); m_rst[n] = r;
  endtask
  task automatic set_stoch(input int n, input int si, input int st, input int mask);
    wr(6, n, 0, si | (st << 1) | (mask << 2));
    m_sti[n] = si; m_stt[n] = st; m_mask[n] = mask;
  endtask
  task automatic set_seed(input int s);
    wr(7, 0, 0, s); m_lf = (s == 0) ? 1 : s;
  endtask

  // one time step: model, drive, compare
  task automatic run_tick(input logic [NA-1:0] ax, input bit mid, input string tag);
    logic [NN-1:0] exp_sp;
    int cycles;
    exp_sp = '0;
    for (int n = 0; n < NN; n++) begin
      int v, eff, r, w;
      v = m_pot[n];
      for (int a = 0; a < NA; a++) begin
        if (ax[a] && m_conn[n][a] != 0) begin
          w = m_wt[n][m_type[a]];
          if (m_sti[n] != 0) begin
            r = draw();
            if (r < ((w < 0) ? -w : w)) v = v + ((w < 0) ? -1 : 1);
          end else begin
            v = v + w;
          end
          v = sat(v);
        end
      end
      v   = sat(v + m_leak[n]);
      eff = m_thr[n];
      if (m_stt[n] != 0) begin
        r   = draw();
        eff = eff + (r & m_mask[n]);
      end
      if (v >= eff) begin
        exp_sp[n] = 1'b1;
        v = m_rst[n];
      end
      m_pot[n] = v;
    end

    @(negedge clk);
    got = '0; last_idx = -1; order_bad = 0; err_cnt = 0;
    axon_in    = ax;
    tick_start = 1'b1;
    cycles     = 0;
    do begin
      @(negedge clk);
      cycles++;
      if (cycles == 1) tick_start = 1'b0;
      if (mid && cycles == 3) tick_start = 1'b1;
      if (mid && cycles == 4) tick_start = 1'b0;
    end while (!tick_done && cycles < 400);
    #1;
    check(got == exp_sp, {tag, " R4 spike set"}, int'(got), int'(exp_sp));
    check(order_bad == 0, {tag, " R9 ascending order"}, order_bad, 0);
    check(cycles == TICK_LEN, {tag, " R10 done timing"}, cycles, TICK_LEN);
    check(err_cnt == (mid ? 1 : 0), {tag, " R11 error pulses"}, err_cnt, mid ? 1 : 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", nerr, ncheck_total());
    $finish;
  end

  function automatic int ncheck_total();
    return nchk;
  endfunction

  initial begin : stim
    for (int n = 0; n < NN; n++) begin
      m_leak[n] = 0; m_thr[n] = 0; m_rst[n] = 0; m_pot[n] = 0;
      m_sti[n] = 0; m_stt[n] = 0; m_mask[n] = 0;
      for (int t = 0; t < 4; t++) m_wt[n][t] = 0;
      for (int a = 0; a < NA; a++) m_conn[n][a] = 0;
    end
    for (int a = 0; a < NA; a++) m_type[a] = 0;
    m_lf = 1;
    got = '0; last_idx = -1; order_bad = 0; err_cnt = 0;
    rst_n = 1'b0; tick_start = 1'b0; axon_in = '0;
    wr_en = 1'b0; wr_kind = '0; wr_row = '0; wr_col = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(spike_valid == 1'b0, "R1 spike_valid after reset", int'(spike_valid), 0);
    check(tick_done == 1'b0, "R1 tick_done after reset", int'(tick_done), 0);
    check(tick_err == 1'b0, "R1 tick_err after reset", int'(tick_err), 0);
    run_tick(8'hFF, 1'b0, "R1 cleared config fires all");

    // R2 R4 R5 R12: deterministic random configurations
    for (int a = 0; a < NA; a++) set_type(a, $urandom_range(0, 3));
    for (int n = 0; n < NN; n++) begin
      for (int t = 0; t < 4; t++) set_wt(n, t, int'($urandom_range(0, 400)) - 150);
      for (int a = 0; a < NA; a++) set_conn(n, a, $urandom_range(0, 1));
      set_leak(n, int'($urandom_range(0, 30)) - 20);
      set_thr(n, $urandom_range(0, 600));
      set_rst(n, int'($urandom_range(0, 100)) - 50);
    end
    for (int k = 0; k < 30; k++) run_tick(8'($urandom), 1'b0, "R2 deterministic");
    // R5: no input, leak only
    for (int k = 0; k < 4; k++) run_tick(8'h00, 1'b0, "R5 leak only");

    // R3: push neuron 0 to the positive limit, neuron 1 to the negative one
    for (int a = 0; a < NA; a++) begin
      set_conn(0, a, 1); set_conn(1, a, 1); set_conn(2, a, 0); set_conn(3, a, 0);
    end
    for (int t = 0; t < 4; t++) begin set_wt(0, t, 255); set_wt(1, t, -256); end
    set_leak(0, 255);  set_thr(0, 524287); set_rst(0, 0);
    set_leak(1, -256); set_thr(1, 0);      set_rst(1, 0);
    set_leak(2, 0); set_thr(2, 524287);
    set_leak(3, 0); set_thr(3, 524287);
    for (int k = 0; k < 240; k++) run_tick(8'hFF, 1'b0, "R3 saturation");
    for (int t = 0; t < 4; t++) set_wt(1, t, 0);
    set_leak(1, 255);
    set_thr(1, -524288 + 700);
    for (int k = 0; k < 4; k++) run_tick(8'hFF, 1'b0, "R3 recover from floor");

    // R6 R7 R8: stochastic modes
    set_seed('hACE1);
    for (int n = 0; n < NN; n++) begin
      for (int t = 0; t < 4; t++) set_wt(n, t, int'($urandom_range(0, 511)) - 256);
      for (int a = 0; a < NA; a++) set_conn(n, a, $urandom_range(0, 1));
      set_leak(n, int'($urandom_range(0, 6)) - 3);
      set_thr(n, $urandom_range(0, 20));
      set_rst(n, 0);
      set_stoch(n, n & 1, (n >> 1) & 1, $urandom_range(0, 255));
    end
    for (int k = 0; k < 40; k++) run_tick(8'($urandom), 1'b0, "R6 R7 stochastic");
    set_seed(0);
    for (int k = 0; k < 6; k++) run_tick(8'hFF, 1'b0, "R8 zero seed");

    // R11: start request during a walk
    for (int k = 0; k < 3; k++) run_tick(8'($urandom), 1'b1, "R11 busy start");

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule